// File: doc/BRIEF.md
# SPI Command Frame Monitor

This block watches a byte-level SPI link to a banked register peripheral without taking part in it. An upstream deserializer hands it one MOSI/MISO byte pair per strobe, together with the chip-select level. Each stretch of bytes exchanged while chip select is active is treated as one command frame. When chip select drops, the monitor decodes the whole frame. It works out the command, the register address, the data byte of interest and the buffer transfer length. It also flags any malformed frame in a warning bitmask.

The peripheral's control registers are spread over four banks. The bank is chosen by two select bits held in a bank-control register at address 0x1F, which every bank shares. The monitor snoops writes, bit-sets and bit-clears aimed at that register, so it always knows which bank later accesses land in. A MAC-class map input and a reserved map input, each indexed by bank and address, let it judge register reads and accesses. The result of each frame is a registered record with a one-cycle valid strobe. The record holds its value until the next frame ends.

Top module: `spi_frame_monitor`

## Requirements
- R1: A frame ends on the first clock where `cs_active` is low after being high. If the frame held at least one byte, `frame_valid` pulses for exactly one cycle on the next clock edge. A frame with no bytes produces no pulse and leaves the record unchanged. Between results, every record output holds its value.
- R2: `cmd` reports bits 7:5 of the first MOSI byte and `addr` reports bits 4:0. The command codes are 000 register read, 001 buffer read, 010 register write, 011 buffer write, 100 bit set, 101 bit clear, 111 reset and 110 unused.
- R3: Command code 110 sets warning bit 0 and no other warning bit.
- R4: A buffer read needs a first byte of exactly 0x3A, and a buffer write needs exactly 0x7A. Any other first byte sets warning bit 1 and reports `len` as 0. A correct first byte reports `len` as the byte count minus one. Every other command reports `len` as 0.
- R5: Writes, bit sets and bit clears must be exactly 2 bytes long. A reset must be exactly 1 byte long. A register read must be 2 or 3 bytes long. Any other length sets warning bit 2 and no other warning bit.
- R6: A register read of correct length compares its length with the register class. A MAC-class register (bank known, `mac_map[bank*32+addr]` set) needs 3 bytes. Any other register needs 2 bytes, and address 0x1F always counts as non-MAC. A mismatch sets warning bit 3. No comparison is made when the bank is unknown and the address is not 0x1F. `data` is MISO byte 1 for a 2-byte read and MISO byte 2 for a 3-byte read.
- R7: A register write, bit set or bit clear of correct length reports MOSI byte 1 in `data`. Buffer, reset and unused commands report `data` as 0.
- R8: A correct-length frame addressed to 0x1F updates the bank select. A register write loads both bits from data bits 1:0. A bit set raises each bit whose data bit is 1. A bit clear lowers each bit whose data bit is 1. Frames of invalid length leave the bank untouched. `bank` and `bank_known` report the state in effect while the frame ran, before its own update.
- R9: Each bank-select bit becomes known on its first update and stays known until reset. A register read, write, set or clear of correct length to an address other than 0x1F sets warning bit 4 when either bit is unknown.
- R10: With the bank known, a correct-length register command to address `a` other than 0x1F sets warning bit 5 when `rsv_map[bank*32+a]` is set.
- R11: The byte count saturates at 2^LEN_W-1, so an overlong buffer frame reports `len` as 2^LEN_W-2.
- R12: After reset, `frame_valid` is 0, every record output is 0 and the bank is unknown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_active | input | 1 | Chip-select active level |
| byte_valid | input | 1 | One MOSI/MISO byte pair is present this cycle |
| mosi_byte | input | 8 | Byte sent to the peripheral |
| miso_byte | input | 8 | Byte returned by the peripheral |
| mac_map | input | 4*32 | MAC-class flag per bank and address |
| rsv_map | input | 4*32 | Reserved flag per bank and address |
| frame_valid | output | 1 | One-cycle strobe: new record |
| cmd | output | 3 | Command code |
| addr | output | 5 | Register address |
| bank | output | 2 | Bank select in effect during the frame |
| bank_known | output | 1 | Both bank-select bits known during the frame |
| data | output | 8 | Data byte of the frame |
| len | output | LEN_W | Buffer transfer length |
| warn | output | 6 | Warning bits: 0 unused code, 1 header, 2 length, 3 read class, 4 bank unknown, 5 reserved |

## Verification
The bench builds the monitor with LEN_W set to 4. This makes the saturation of the byte counter reachable: a 20-byte buffer frame runs the counter into its ceiling of 15. The default width of 16 would need frames of tens of thousands of bytes. The MAC-class and reserved maps come from the fixed random seed. This puts both register classes, in several banks, within reach of the random frames. Bank-tracking frames to 0x1F are weighted up, so the read-class and reserved checks run against changing banks.

// File: rtl/spimon_pkg.sv
package spimon_pkg;
  typedef enum logic [2:0] {
    OP_RDREG = 3'b000,
    OP_RDBUF = 3'b001,
    OP_WRREG = 3'b010,
    OP_WRBUF = 3'b011,
    OP_BSET  = 3'b100,
    OP_BCLR  = 3'b101,
    OP_NONE  = 3'b110,
    OP_RESET = 3'b111
  } op_e;

  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 5;
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int WARN_W   = 6;

  localparam int W_UNK_OP = 0;
  localparam int W_HDR    = 1;
  localparam int W_LEN    = 2;
  localparam int W_CLASS  = 3;
  localparam int W_BANK   = 4;
  localparam int W_RSV    = 5;

  localparam logic [ADDR_W-1:0] BANK_REG_ADDR = 5'h1F;
  localparam logic [BYTE_W-1:0] RDBUF_HDR     = 8'h3A;
  localparam logic [BYTE_W-1:0] WRBUF_HDR     = 8'h7A;
endpackage

// File: rtl/frame_capture.sv
module frame_capture
  import spimon_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_active,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] mosi_byte,
  input  logic [BYTE_W-1:0] miso_byte,
  output logic              frame_end,
  output logic [LEN_W-1:0]  cnt,
  output logic [BYTE_W-1:0] hdr,
  output logic [BYTE_W-1:0] mosi1,
  output logic [BYTE_W-1:0] miso1,
  output logic [BYTE_W-1:0] miso2
);
  localparam logic [LEN_W-1:0] CNT_MAX = '1;
  localparam logic [LEN_W-1:0] IDX0    = LEN_W'(0);
  localparam logic [LEN_W-1:0] IDX1    = LEN_W'(1);
  localparam logic [LEN_W-1:0] IDX2    = LEN_W'(2);

  logic cs_q;
  logic take;

  assign frame_end = cs_q & ~cs_active;
  assign take      = cs_active & byte_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= 1'b0;
      cnt   <= '0;
      hdr   <= '0;
      mosi1 <= '0;
      miso1 <= '0;
      miso2 <= '0;
    end else begin
      cs_q <= cs_active;
      if (frame_end) begin
        cnt <= '0;
      end else if (take) begin
        if (cnt == IDX0) hdr <= mosi_byte;
        if (cnt == IDX1) begin
          mosi1 <= mosi_byte;
          miso1 <= miso_byte;
        end
        if (cnt == IDX2) miso2 <= miso_byte;
        if (cnt != CNT_MAX) cnt <= cnt + IDX1;
      end
    end
  end

  // R1: the count only moves when a byte is taken or a frame closes
  p_count_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!take && !frame_end) |=> $stable(cnt));

  // R11: the count never wraps from its ceiling back to zero inside a frame
  p_count_sat_r11: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !frame_end) |=> cnt == CNT_MAX);
endmodule

// File: rtl/bank_tracker.sv
module bank_tracker
  import spimon_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [2:0]        op,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BANK_W-1:0] bsel,
  output logic [BANK_W-1:0] known
);
  for (genvar i = 0; i < BANK_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        bsel[i]  <= 1'b0;
        known[i] <= 1'b0;
      end else if (upd) begin
        if (op == OP_WRREG) begin
          bsel[i]  <= wdata[i];
          known[i] <= 1'b1;
        end else if (op == OP_BSET && wdata[i]) begin
          bsel[i]  <= 1'b1;
          known[i] <= 1'b1;
        end else if (op == OP_BCLR && wdata[i]) begin
          bsel[i]  <= 1'b0;
          known[i] <= 1'b1;
        end
      end
    end

    // R9: a select bit once known stays known until reset
    p_known_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      known[i] |=> known[i]);

    // R8: without an update the select bit holds
    p_sel_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !upd |=> $stable(bsel[i]));
  end
endmodule

// File: rtl/frame_decoder.sv
module frame_decoder
  import spimon_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int BANK_W = 2,
  localparam int MAP_W = (1 << BANK_W) * NUM_REGS,
  localparam int IDX_W = BANK_W + ADDR_W
) (
  input  logic [LEN_W-1:0]  cnt,
  input  logic [BYTE_W-1:0] hdr,
  input  logic [BYTE_W-1:0] mosi1,
  input  logic [BYTE_W-1:0] miso1,
  input  logic [BYTE_W-1:0] miso2,
  input  logic [BANK_W-1:0] bsel,
  input  logic [BANK_W-1:0] known,
  input  logic [MAP_W-1:0]  mac_map,
  input  logic [MAP_W-1:0]  rsv_map,
  output logic [WARN_W-1:0] warn,
  output logic [BYTE_W-1:0] data,
  output logic [LEN_W-1:0]  len,
  output logic              bank_upd
);
  localparam logic [LEN_W-1:0] N1 = LEN_W'(1);
  localparam logic [LEN_W-1:0] N2 = LEN_W'(2);
  localparam logic [LEN_W-1:0] N3 = LEN_W'(3);

  logic [2:0]        op;
  logic [ADDR_W-1:0] a;
  logic [IDX_W-1:0]  idx;
  logic              shared, all_known, mac_eff;

  assign op        = hdr[7:5];
  assign a         = hdr[ADDR_W-1:0];
  assign idx       = {bsel, a};
  assign shared    = (a == BANK_REG_ADDR);
  assign all_known = &known;
  assign mac_eff   = !shared && all_known && mac_map[idx];

  always_comb begin
    warn     = '0;
    data     = '0;
    len      = '0;
    bank_upd = 1'b0;
    unique case (op)
      OP_RDREG: begin
        if (cnt != N2 && cnt != N3) begin
          warn[W_LEN] = 1'b1;
        end else begin
          if (!shared) begin
            if (!all_known) warn[W_BANK] = 1'b1;
            else if (rsv_map[idx]) warn[W_RSV] = 1'b1;
          end
          if ((all_known || shared) && (mac_eff != (cnt == N3)))
            warn[W_CLASS] = 1'b1;
          data = (cnt == N2) ? miso1 : miso2;
        end
      end
      OP_WRREG, OP_BSET, OP_BCLR: begin
        if (cnt != N2) begin
          warn[W_LEN] = 1'b1;
        end else begin
          if (!shared) begin
            if (!all_known) warn[W_BANK] = 1'b1;
            else if (rsv_map[idx]) warn[W_RSV] = 1'b1;
          end
          data     = mosi1;
          bank_upd = shared;
        end
      end
      OP_RDBUF: begin
        if (hdr != RDBUF_HDR) warn[W_HDR] = 1'b1;
        else len = cnt - N1;
      end
      OP_WRBUF: begin
        if (hdr != WRBUF_HDR) warn[W_HDR] = 1'b1;
        else len = cnt - N1;
      end
      OP_RESET: begin
        if (cnt != N1) warn[W_LEN] = 1'b1;
      end
      default: warn[W_UNK_OP] = 1'b1;
    endcase
  end
endmodule

// File: rtl/spi_frame_monitor.sv
module spi_frame_monitor
  import spimon_pkg::*;
#(
  parameter int LEN_W  = 16,
  parameter int BANK_W = 2,
  localparam int MAP_W = (1 << BANK_W) * NUM_REGS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_active,
  input  logic              byte_valid,
  input  logic [7:0]        mosi_byte,
  input  logic [7:0]        miso_byte,
  input  logic [MAP_W-1:0]  mac_map,
  input  logic [MAP_W-1:0]  rsv_map,
  output logic              frame_valid,
  output logic [2:0]        cmd,
  output logic [4:0]        addr,
  output logic [BANK_W-1:0] bank,
  output logic              bank_known,
  output logic [7:0]        data,
  output logic [LEN_W-1:0]  len,
  output logic [WARN_W-1:0] warn
);
  logic              frame_end;
  logic [LEN_W-1:0]  cnt;
  logic [BYTE_W-1:0] hdr, mosi1, miso1, miso2;
  logic [BANK_W-1:0] bsel, known;
  logic [WARN_W-1:0] d_warn;
  logic [BYTE_W-1:0] d_data;
  logic [LEN_W-1:0]  d_len;
  logic              d_upd;
  logic              publish;

  frame_capture #(.LEN_W(LEN_W)) i_capture (
    .clk, .rst, .cs_active, .byte_valid, .mosi_byte, .miso_byte,
    .frame_end, .cnt, .hdr, .mosi1, .miso1, .miso2
  );

  frame_decoder #(.LEN_W(LEN_W), .BANK_W(BANK_W)) i_decoder (
    .cnt, .hdr, .mosi1, .miso1, .miso2, .bsel, .known,
    .mac_map, .rsv_map,
    .warn(d_warn), .data(d_data), .len(d_len), .bank_upd(d_upd)
  );

  assign publish = frame_end && (cnt != '0);

  bank_tracker #(.BANK_W(BANK_W)) i_bank (
    .clk, .rst, .upd(publish && d_upd), .op(hdr[7:5]), .wdata(mosi1),
    .bsel, .known
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_valid <= 1'b0;
      cmd         <= '0;
      addr        <= '0;
      bank        <= '0;
      bank_known  <= 1'b0;
      data        <= '0;
      len         <= '0;
      warn        <= '0;
    end else begin
      frame_valid <= publish;
      if (publish) begin
        cmd        <= hdr[7:5];
        addr       <= hdr[ADDR_W-1:0];
        bank       <= bsel;
        bank_known <= &known;
        data       <= d_data;
        len        <= d_len;
        warn       <= d_warn;
      end
    end
  end

  // R1: the result strobe lasts a single cycle
  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> !frame_valid);

  // R1: the record holds between results
  p_record_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |-> $stable(warn) && $stable(len) && $stable(data));

  // R4: only buffer commands carry a nonzero length
  p_len_buffer_r4: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && len != '0) |-> (cmd == OP_RDBUF || cmd == OP_WRBUF));

  // R3: the unused code raises only its own warning
  p_unk_alone_r3: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && cmd == OP_NONE) |-> warn == WARN_W'(1 << W_UNK_OP));

  // R9: a known bank never yields a bank-unknown warning
  p_bank_warn_r9: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && bank_known) |-> !warn[W_BANK]);

  // R5: a length warning stands alone
  p_len_alone_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && warn[W_LEN]) |-> $countones(warn) == 1);
endmodule

// File: tb/test_spi_frame_monitor.sv
module test_spi_frame_monitor;
  localparam int LEN_W = 4;
  localparam int CMAX  = (1 << LEN_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_active = 1'b0;
  logic byte_valid = 1'b0;
  logic [7:0] mosi_byte = '0;
  logic [7:0] miso_byte = '0;
  logic [127:0] mac_map = '0;
  logic [127:0] rsv_map = '0;
  logic frame_valid;
  logic [2:0] cmd;
  logic [4:0] addr;
  logic [1:0] bank;
  logic bank_known;
  logic [7:0] data;
  logic [LEN_W-1:0] len;
  logic [5:0] warn;

  spi_frame_monitor #(.LEN_W(LEN_W), .BANK_W(2)) i_spi_frame_monitor (
    .clk, .rst, .cs_active, .byte_valid, .mosi_byte, .miso_byte,
    .mac_map, .rsv_map, .frame_valid, .cmd, .addr, .bank, .bank_known,
    .data, .len, .warn
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [1:0] mb = 2'b00;
  logic [1:0] mk = 2'b00;
  logic [7:0] fm [0:31];
  logic [7:0] fs [0:31];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // Send one frame of n bytes from fm/fs and check the record against the model
  task automatic do_frame(input int n, input string tag);
    int c;
    logic [2:0] op;
    logic [4:0] a;
    logic shared, allk, macf;
    logic [6:0] idx;
    logic [5:0] ew;
    logic [7:0] ed;
    logic [LEN_W-1:0] el;
    logic upd;
    @(negedge clk);
    cs_active = 1'b1;
    for (int i = 0; i < n; i++) begin
      byte_valid = 1'b1;
      mosi_byte = fm[i % 32];
      miso_byte = fs[i % 32];
      @(negedge clk);
      byte_valid = 1'b0;
      if ($urandom % 4 == 0) @(negedge clk);
    end
    cs_active = 1'b0;
    @(posedge clk);
    @(negedge clk);
    if (n == 0) begin
      chk({"R1 empty ", tag}, frame_valid, 0);
      return;
    end
    c = (n > CMAX) ? CMAX : n;
    op = fm[0][7:5];
    a = fm[0][4:0];
    shared = (a == 5'h1F);
    allk = &mk;
    idx = {mb, a};
    ew = '0; ed = '0; el = '0; upd = 0;
    case (op)
      3'd0: begin
        if (c != 2 && c != 3) ew[2] = 1;
        else begin
          if (!shared && !allk) ew[4] = 1;
          else if (!shared && rsv_map[idx]) ew[5] = 1;
          macf = !shared && allk && mac_map[idx];
          if ((allk || shared) && (macf != (c == 3))) ew[3] = 1;
          ed = (c == 2) ? fs[1] : fs[2];
        end
      end
      3'd2, 3'd4, 3'd5: begin
        if (c != 2) ew[2] = 1;
        else begin
          if (!shared && !allk) ew[4] = 1;
          else if (!shared && rsv_map[idx]) ew[5] = 1;
          ed = fm[1];
          upd = shared;
        end
      end
      3'd1: if (fm[0] != 8'h3A) ew[1] = 1; else el = LEN_W'(c - 1);
      3'd3: if (fm[0] != 8'h7A) ew[1] = 1; else el = LEN_W'(c - 1);
      3'd7: if (c != 1) ew[2] = 1;
      default: ew[0] = 1;
    endcase
    chk({"R1 valid ", tag}, frame_valid, 1);
    chk({"R2 cmd ", tag}, cmd, op);
    chk({"R2 addr ", tag}, addr, a);
    chk({"R8 bank ", tag}, bank, mb);
    chk({"R9 bank_known ", tag}, bank_known, allk);
    chk({"R7 data ", tag}, data, ed);
    chk({"R4 len ", tag}, len, el);
    chk({"warn ", tag}, warn, ew);
    if (upd) begin
      for (int b = 0; b < 2; b++) begin
        if (op == 3'd2) begin mb[b] = fm[1][b]; mk[b] = 1; end
        else if (fm[1][b]) begin mb[b] = (op == 3'd4); mk[b] = 1; end
      end
    end
  endtask

  task automatic set2(input logic [7:0] h, input logic [7:0] d);
    fm[0] = h; fm[1] = d;
  endtask

  initial begin
    int pick;
    void'($urandom(32'h5EED_0042));
    mac_map = {$urandom, $urandom, $urandom, $urandom};
    rsv_map = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
    for (int i = 0; i < 32; i++) begin fm[i] = 8'($urandom); fs[i] = 8'($urandom); end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 valid", frame_valid, 0);
    chk("R12 record", {cmd, addr, bank, bank_known, data, len, warn}, 0);

    do_frame(0, "empty");
    chk("R1 hold after empty", {cmd, addr, data, len, warn}, 0);

    set2({3'b000, 5'h05}, 8'h00); do_frame(2, "R9 read bank unknown");
    set2({3'b100, 5'h1F}, 8'h01); do_frame(2, "R8 set bit0");
    set2({3'b010, 5'h02}, 8'h11); do_frame(2, "R9 one bit known");
    @(negedge clk);
    chk("R1 strobe drops", frame_valid, 0);
    chk("R1 record holds", addr, 5'h02);
    set2({3'b101, 5'h1F}, 8'h02); do_frame(2, "R8 clear bit1");
    set2({3'b010, 5'h1F}, 8'h03); do_frame(2, "R8 write bank");
    set2({3'b010, 5'h1F}, 8'h00); do_frame(3, "R5 bad length no update");
    set2({3'b000, 5'h1F}, 8'h00); do_frame(2, "R6 read shared");
    set2({3'b000, 5'h1F}, 8'h00); do_frame(3, "R6 shared with dummy");
    pick = -1;
    for (int i = 0; i < 31; i++) if (pick < 0 && mac_map[{2'b11, 5'(i)}]) pick = i;
    if (pick >= 0) begin
      set2({3'b000, 5'(pick)}, 8'h00); do_frame(3, "R6 mac read");
      set2({3'b000, 5'(pick)}, 8'h00); do_frame(2, "R6 mac no dummy");
    end
    pick = -1;
    for (int i = 0; i < 31; i++) if (pick < 0 && rsv_map[{2'b11, 5'(i)}]) pick = i;
    if (pick >= 0) begin
      set2({3'b010, 5'(pick)}, 8'h55); do_frame(2, "R10 reserved");
    end
    fm[0] = 8'h3A; do_frame(5, "R4 read buffer");
    fm[0] = 8'h3B; do_frame(5, "R4 bad header");
    fm[0] = 8'h7A; do_frame(20, "R11 saturate");
    fm[0] = 8'hFF; do_frame(1, "R5 reset ok");
    fm[0] = 8'hE0; do_frame(2, "R5 reset long");
    fm[0] = 8'hC3; do_frame(2, "R3 unused code");
    set2({3'b101, 5'h1F}, 8'h03); do_frame(2, "R8 clear both");

    for (int k = 0; k < 300; k++) begin
      int n;
      for (int i = 0; i < 32; i++) begin fm[i] = 8'($urandom); fs[i] = 8'($urandom); end
      if ($urandom % 4 == 0) fm[0][4:0] = 5'h1F;
      if (fm[0][7:5] == 3'd1 && $urandom % 2 == 0) fm[0] = 8'h3A;
      if (fm[0][7:5] == 3'd3 && $urandom % 2 == 0) fm[0] = 8'h7A;
      n = ($urandom % 8 == 0) ? int'($urandom % 20) : int'($urandom % 5);
      do_frame(n, "random");
    end
    finish_run();
  end
endmodule